// File: doc/BRIEF.md
# PCI Segment Clock Mode Selector

This block settles the operating mode and the clock rate of one PCI / PCI-X bus segment. It reads the segment's configuration straps: a line saying whether all devices can run at 66 MHz, a strap saying whether all devices are PCI-X capable, and a strap that allows 133 MHz in PCI-X mode. From these it produces a one-hot rate select for the clock generator and a PCI-X mode flag.

The 66 MHz line is shared with the board. The block can pull it low through a tri-state pad driver. It does so when hot plug is enabled at power-up, or once software writes 00 to the block's 2-bit rate register. It never drives the line in single-slot hot-plug mode without glue logic. Whenever the block drives the line, it takes the driven low level as the line's value. The segment then runs as conventional PCI at 33 MHz.

The straps, the two hot-plug flags and the 66 MHz level are captured on the first clock edge after reset releases. They are captured again on every write to the rate register. Between these capture events they are held.

Top module: `pci_clkmode_top`

## Requirements
- R1: While reset is asserted, and after it until the first capture edge, `rate_sel` is 4'b0001 (33 MHz), `pcix_mode` is 0 and `m66_oe` is 0.
- R2: With PCI-X not captured and the pad not driven, a captured 66 MHz level of 1 gives `rate_sel` 4'b0010 (66 MHz), and a level of 0 gives 4'b0001 (33 MHz).
- R3: With the PCI-X capable strap captured high and the pad not driven, `pcix_mode` is 1. `rate_sel` is 4'b1000 (133 MHz) when the 133 MHz strap is captured high, and 4'b0100 (100 MHz) when it is low.
- R4: If hot plug is enabled at the first capture after reset and single-slot mode is off, `m66_oe` is 1 from that edge, and the outputs show 33 MHz conventional mode (`rate_sel` 4'b0001, `pcix_mode` 0).
- R5: A write of 2'b00 makes `m66_oe` 1 from the clock edge that accepts the write, unless single-slot mode is captured. The drive-low state then stays set through later non-00 writes until reset.
- R6: With hot plug disabled at power-up and no write of 00 since reset, `m66_oe` stays 0.
- R7: While single-slot mode is captured, `m66_oe` is 0 whatever the rate register holds. The rate decision then uses the captured pad level.
- R8: Changes on the strap and pad inputs have no effect on the outputs except at a capture edge (the first edge after reset, or a write edge).
- R9: `rate_sel` has exactly one bit set on every cycle.
- R10: `m66_out`, the value presented to the pad driver, is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m66_in | input | 1 | Sampled level of the shared 66 MHz enable line |
| pcix_cap_in | input | 1 | All devices PCI-X capable strap |
| en133_in | input | 1 | Allow 133 MHz in PCI-X mode strap |
| hp_en_in | input | 1 | Hot plug enabled flag |
| hp_single_in | input | 1 | Single-slot, no-glue hot-plug mode flag |
| wr_en | input | 1 | Software write strobe for the rate register |
| wr_data | input | 2 | Write data for the rate register |
| rate_sel | output | 4 | One-hot rate: bit0 33, bit1 66, bit2 100, bit3 133 MHz |
| pcix_mode | output | 1 | Segment runs in PCI-X mode |
| m66_oe | output | 1 | Output enable of the 66 MHz line pad driver |
| m66_out | output | 1 | Value driven on the 66 MHz line when enabled |

## Verification
The assertions check these properties on every cycle:
- the one-hot rate select;
- the constant low drive value;
- that an enabled pad forces 33 MHz conventional mode;
- that single-slot mode never enables the driver;
- that the drive-low state is sticky;
- that the outputs hold steady between capture edges.

Some behaviours need the bench's scenarios, because they depend on the exact cycle of capture and on which inputs were present at that edge:
- which rate a given strap combination yields;
- that hot plug at power-up, rather than later, turns the driver on;
- that a write of 00 enables the driver on its own edge.

// File: rtl/pci_clkmode_pkg.sv
package pci_clkmode_pkg;

  localparam int RATE_N = 4;
  localparam int REG_W  = 2;

  typedef logic [RATE_N-1:0] rate_t;

  localparam rate_t RATE_33  = 4'b0001;
  localparam rate_t RATE_66  = 4'b0010;
  localparam rate_t RATE_100 = 4'b0100;
  localparam rate_t RATE_133 = 4'b1000;

  typedef struct packed {
    logic m66;
    logic pcix_cap;
    logic en133;
    logic hp_en;
    logic hp_single;
  } straps_t;

  // Rate decision from effective line level and straps.
  function automatic rate_t pick_rate(input logic pcix, input logic en133,
                                      input logic m66_eff);
    if (pcix)
      return en133 ? RATE_133 : RATE_100;
    return m66_eff ? RATE_66 : RATE_33;
  endfunction

  // True when a written register value requests the low-drive state.
  function automatic logic is_force_low(input logic [REG_W-1:0] val);
    return (val == '0);
  endfunction

endpackage

// File: rtl/pci_strap_capture.sv
module pci_strap_capture
  import pci_clkmode_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  straps_t  straps_in,
  input  logic     wr_en,
  output straps_t  straps_q,
  output logic     cap_evt,
  output logic     first_cap
);

  logic armed_q;

  assign first_cap = armed_q;
  assign cap_evt   = armed_q | wr_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q  <= 1'b1;
      straps_q <= '0;
    end else begin
      armed_q <= 1'b0;
      if (cap_evt)
        straps_q <= straps_in;
    end
  end

  AST_ARM_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |=> !armed_q); // R8

endmodule

// File: rtl/pci_drive_ctrl.sv
module pci_drive_ctrl
  import pci_clkmode_pkg::*;
#(
  parameter logic [REG_W-1:0] RST_VAL = 2'b11
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             first_cap,
  input  logic             hp_en,
  input  logic             hp_single,
  input  logic             single_q,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic             drive_low_q,
  output logic             pad_oe
);

  logic [REG_W-1:0] rate_reg_q;
  logic             set_hp;
  logic             set_sw;

  assign set_hp = first_cap & hp_en & ~hp_single;
  assign set_sw = wr_en & is_force_low(wr_data);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate_reg_q  <= RST_VAL;
      drive_low_q <= 1'b0;
    end else begin
      if (wr_en)
        rate_reg_q <= wr_data;
      if (set_hp | set_sw)
        drive_low_q <= 1'b1;
    end
  end

  assign pad_oe = drive_low_q & ~single_q;

  AST_STICKY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    drive_low_q |=> drive_low_q); // R5
  AST_SINGLE_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
    single_q |-> !pad_oe); // R7
  AST_REG_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_reg_q == '0) |-> drive_low_q); // R5

endmodule

// File: rtl/pci_mode_decide.sv
module pci_mode_decide
  import pci_clkmode_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  straps_t straps_q,
  input  logic    pad_oe,
  output rate_t   rate_sel,
  output logic    pcix_mode
);

  logic m66_eff;
  logic pcix_eff;

  // When driving, the line is known to be low and mode is conventional.
  assign m66_eff   = pad_oe ? 1'b0 : straps_q.m66;
  assign pcix_eff  = straps_q.pcix_cap & ~pad_oe;
  assign pcix_mode = pcix_eff;
  assign rate_sel  = pick_rate(pcix_eff, straps_q.en133, m66_eff);

  AST_ONEHOT_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rate_sel) == 1); // R9
  AST_OE_CONV33: assert property (@(posedge clk) disable iff (!rst_n)
    pad_oe |-> (rate_sel == RATE_33 && !pcix_mode)); // R4
  AST_PCIX_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    pcix_mode |-> (rate_sel[2] | rate_sel[3])); // R3

endmodule

// File: rtl/pci_clkmode_top.sv
module pci_clkmode_top
  import pci_clkmode_pkg::*;
#(
  parameter logic [REG_W-1:0] RST_VAL = 2'b11
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             m66_in,
  input  logic             pcix_cap_in,
  input  logic             en133_in,
  input  logic             hp_en_in,
  input  logic             hp_single_in,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [RATE_N-1:0] rate_sel,
  output logic             pcix_mode,
  output logic             m66_oe,
  output logic             m66_out
);

  straps_t straps_in;
  straps_t straps_q;
  logic    cap_evt;
  logic    first_cap;
  logic    drive_low_q;
  logic    pad_oe;
  rate_t   rate_w;

  assign straps_in = '{m66: m66_in, pcix_cap: pcix_cap_in, en133: en133_in,
                       hp_en: hp_en_in, hp_single: hp_single_in};

  pci_strap_capture u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .straps_in (straps_in),
    .wr_en     (wr_en),
    .straps_q  (straps_q),
    .cap_evt   (cap_evt),
    .first_cap (first_cap)
  );

  pci_drive_ctrl #(.RST_VAL(RST_VAL)) u_drv (
    .clk         (clk),
    .rst_n       (rst_n),
    .first_cap   (first_cap),
    .hp_en       (hp_en_in),
    .hp_single   (hp_single_in),
    .single_q    (straps_q.hp_single),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .drive_low_q (drive_low_q),
    .pad_oe      (pad_oe)
  );

  pci_mode_decide u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .straps_q  (straps_q),
    .pad_oe    (pad_oe),
    .rate_sel  (rate_w),
    .pcix_mode (pcix_mode)
  );

  assign rate_sel = rate_w;
  assign m66_oe   = pad_oe;
  assign m66_out  = 1'b0;

  AST_DRIVE_LOW_VAL: assert property (@(posedge clk) disable iff (!rst_n)
    m66_oe |-> !m66_out); // R10
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_evt && $past(rst_n)) |=> ($stable(rate_sel) && $stable(pcix_mode))); // R8

endmodule

// File: tb/pci_clkmode_top_test.sv
`timescale 1ns/1ps
module pci_clkmode_top_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       m66_in, pcix_cap_in, en133_in, hp_en_in, hp_single_in;
  logic       wr_en;
  logic [1:0] wr_data;
  logic [3:0] rate_sel;
  logic       pcix_mode, m66_oe, m66_out;

  int n_tests = 0;
  int n_fail  = 0;

  // bench model state
  logic armed, dl, c_m66, c_pcix, c_133, c_single;

  always #2.5 clk = ~clk;

  pci_clkmode_top uut (
    .clk(clk), .rst_n(rst_n), .m66_in(m66_in), .pcix_cap_in(pcix_cap_in),
    .en133_in(en133_in), .hp_en_in(hp_en_in), .hp_single_in(hp_single_in),
    .wr_en(wr_en), .wr_data(wr_data), .rate_sel(rate_sel),
    .pcix_mode(pcix_mode), .m66_oe(m66_oe), .m66_out(m66_out)
  );

  function automatic logic [3:0] exp_rate(input logic oe);
    if (oe) return 4'b0001;
    if (c_pcix) return c_133 ? 4'b1000 : 4'b0100;
    return c_m66 ? 4'b0010 : 4'b0001;
  endfunction

  function automatic logic exp_oe();
    return dl & ~c_single;
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all(input string req);
    logic oe;
    oe = exp_oe();
    check(req, {3'b0, m66_oe}, {3'b0, oe});
    check(req, rate_sel, exp_rate(oe));
    check(req, {3'b0, pcix_mode}, {3'b0, c_pcix & ~oe});
    check("R10", {3'b0, m66_out}, 4'b0);
    check("R9", {3'b0, ($countones(rate_sel) == 1)}, 4'b1);
  endtask

  // One clock: inputs set now (negedge), model follows the edge, check at next negedge.
  task automatic step(input string req);
    @(posedge clk);
    if (!rst_n) begin
      armed = 1; dl = 0; c_m66 = 0; c_pcix = 0; c_133 = 0; c_single = 0;
    end else begin
      if (armed && hp_en_in && !hp_single_in) dl = 1;
      if (wr_en && wr_data == 2'b00) dl = 1;
      if (armed || wr_en) begin
        c_m66 = m66_in; c_pcix = pcix_cap_in; c_133 = en133_in; c_single = hp_single_in;
      end
      armed = 0;
    end
    @(negedge clk);
    check_all(req);
  endtask

  task automatic set_straps(input logic m, input logic x, input logic f,
                            input logic h, input logic s);
    m66_in = m; pcix_cap_in = x; en133_in = f; hp_en_in = h; hp_single_in = s;
  endtask

  task automatic do_reset(input logic m, input logic x, input logic f,
                          input logic h, input logic s);
    rst_n = 0; wr_en = 0; wr_data = 2'b11;
    set_straps(m, x, f, h, s);
    step("R1");
    step("R1");
    rst_n = 1;
    step("capture");
  endtask

  task automatic write(input logic [1:0] d, input string req);
    wr_en = 1; wr_data = d;
    step(req);
    wr_en = 0;
  endtask

  initial begin
    #200000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; wr_en = 0; wr_data = 2'b11;
    set_straps(0, 0, 0, 0, 0);
    armed = 1; dl = 0; c_m66 = 0; c_pcix = 0; c_133 = 0; c_single = 0;
    @(negedge clk);
    // R1: reset state
    step("R1");
    check("R1", rate_sel, 4'b0001);
    // R2: conventional 66 and 33
    do_reset(1, 0, 0, 0, 0);
    check("R2", rate_sel, 4'b0010);
    do_reset(0, 0, 1, 0, 0);
    check("R2", rate_sel, 4'b0001);
    // R3: PCI-X 133 and 100
    do_reset(1, 1, 1, 0, 0);
    check("R3", rate_sel, 4'b1000);
    check("R3", {3'b0, pcix_mode}, 4'b0001);
    do_reset(0, 1, 0, 0, 0);
    check("R3", rate_sel, 4'b0100);
    // R6: no hot plug, no write 00
    check("R6", {3'b0, m66_oe}, 4'b0);
    write(2'b10, "R6");
    check("R6", {3'b0, m66_oe}, 4'b0);
    // R4: hot plug at power-up
    do_reset(1, 1, 1, 1, 0);
    check("R4", {3'b0, m66_oe}, 4'b0001);
    check("R4", rate_sel, 4'b0001);
    // R4 only at power-up: hot plug raised later does not drive
    do_reset(1, 0, 0, 0, 0);
    hp_en_in = 1;
    step("R4");
    check("R4", {3'b0, m66_oe}, 4'b0);
    // R5: write 00 then sticky
    do_reset(1, 1, 0, 0, 0);
    write(2'b00, "R5");
    check("R5", {3'b0, m66_oe}, 4'b0001);
    write(2'b11, "R5");
    check("R5", {3'b0, m66_oe}, 4'b0001);
    check("R5", rate_sel, 4'b0001);
    // R7: single slot never drives
    do_reset(1, 0, 0, 1, 1);
    check("R7", {3'b0, m66_oe}, 4'b0);
    check("R7", rate_sel, 4'b0010);
    write(2'b00, "R7");
    check("R7", {3'b0, m66_oe}, 4'b0);
    // R8: inputs ignored between captures
    do_reset(0, 0, 0, 0, 0);
    set_straps(1, 1, 1, 0, 0);
    step("R8");
    step("R8");
    check("R8", rate_sel, 4'b0001);
    write(2'b01, "R8");
    check("R8", rate_sel, 4'b1000);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      set_straps($urandom_range(1), $urandom_range(1), $urandom_range(1),
                 $urandom_range(1), ($urandom_range(3) == 0));
      wr_en   = ($urandom_range(7) == 0);
      wr_data = 2'($urandom_range(3));
      rst_n   = ($urandom_range(63) != 0);
      step("R8");
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule